// File: doc/BRIEF.md
# Interframe Space Sequencer

This block follows the gap between frames on a two-wire, CAN-style serial bus, one sampled bit at a time. The bit timing logic supplies a one-cycle strobe together with the sampled bus level. The frame logic reports the last bit of a frame, whether this node transmitted that frame, the node's error-passive status, a pending request to transmit, and the start of an error or overload frame. From these inputs the sequencer works out which gap phase the bus is in. It grants a start-of-frame slot only at the point where a new data or remote frame may legally begin.

Every frame is followed by a fixed run of recessive intermission bits. If the node is error passive and has just sent the frame, a longer recessive suspend field comes next. After that the bus is idle for as long as it stays recessive. A pending frame gets its permit on the first bit after the gap, so it does not have to wait in idle. A dominant bit during intermission is reported as an overload condition. A dominant bit during suspend or idle is taken to be another node's start-of-frame. Error and overload frames may start at any point, with no gap before them.

Top module: `ifs_sequencer`

## Requirements
- R1: While the synchronous reset `rst` is high, and on the first cycle after it, `phase` is idle (2'd0), and `sof_permit` and `overload` are 0.
- R2: A strobe with `eof_done` high puts `phase` in intermission (2'd1). It stays there for exactly INTER_BITS (default 3) further recessive strobes (`bus_bit` = 1 is recessive, 0 is dominant). The eof strobe also clears `overload`.
- R3: If `err_passive` and `tx_was_mine` are both high at the eof strobe, the gap continues into suspend (2'd2) for exactly SUSP_BITS (default 8) recessive strobes, and then goes to idle.
- R4: If either `err_passive` or `tx_was_mine` is low at the eof strobe, the gap goes from intermission straight to idle.
- R5: Idle lasts for any number of recessive strobes. A dominant strobe in idle moves `phase` to frame (2'd3).
- R6: `sof_permit` is high exactly when `phase` is idle and `tx_pending` was high at the latest strobe. A pending frame therefore gets the permit on the first bit after intermission, or after suspend when suspend applies.
- R7: A dominant strobe during intermission sets `overload` and moves `phase` to frame. Both stay that way until the next eof strobe.
- R8: A dominant strobe during suspend moves `phase` to frame with `sof_permit` low, even while `tx_pending` is high.
- R9: A strobe with `errovl_start` high moves `phase` to frame from any phase. It takes priority over `eof_done`.
- R10: `phase`, `sof_permit` and `overload` change only on cycles with `bit_tick` high. On other cycles, `bus_bit`, `eof_done` and `errovl_start` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe marking a sampled bit |
| bus_bit | input | 1 | Sampled bus level, 1 recessive, 0 dominant |
| eof_done | input | 1 | This strobe's bit closed a frame |
| tx_was_mine | input | 1 | This node transmitted the frame that is ending |
| err_passive | input | 1 | Node is in the error-passive state |
| tx_pending | input | 1 | Node has a frame waiting to send |
| errovl_start | input | 1 | An error or overload frame starts at this strobe |
| phase | output | 2 | 0 idle, 1 intermission, 2 suspend, 3 frame |
| sof_permit | output | 1 | Node may drive start-of-frame on the next bit |
| overload | output | 1 | Dominant bit seen during intermission |

## Verification
The bench uses the default field lengths, INTER_BITS = 3 and SUSP_BITS = 8. With these values, every gap path can be walked bit by bit in a few dozen strobes: the plain gap, the gap with suspend, and dominant bits arriving at each position. Strobes come every fourth clock. The cycles between strobes carry opposite bus levels and spurious eof and error pulses, so any sensitivity outside the strobe shows up against the reference model.

// File: rtl/ifs_pkg.sv
package ifs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE         = 2'd0,
    PH_INTERMISSION = 2'd1,
    PH_SUSPEND      = 2'd2,
    PH_FRAME        = 2'd3
  } ifs_phase_e;
endpackage

// File: rtl/ifs_field_counter.sv
module ifs_field_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (inc)   count <= count + 1'b1;
  end
endmodule

// File: rtl/ifs_suspend_flag.sv
module ifs_suspend_flag (
  input  logic clk,
  input  logic rst,
  input  logic capture,
  input  logic err_passive,
  input  logic tx_was_mine,
  output logic need_suspend
);
  // Decided once per frame end; held for the whole gap that follows.
  always_ff @(posedge clk) begin
    if (rst)          need_suspend <= 1'b0;
    else if (capture) need_suspend <= err_passive & tx_was_mine;
  end
endmodule

// File: rtl/ifs_phase_ctrl.sv
module ifs_phase_ctrl
  import ifs_pkg::*;
#(
  parameter int INTER_BITS = 3,
  parameter int SUSP_BITS  = 8,
  parameter int CNT_W      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_tick,
  input  logic             bus_bit,
  input  logic             eof_done,
  input  logic             errovl_start,
  input  logic             tx_pending,
  input  logic             need_suspend,
  input  logic [CNT_W-1:0] count,
  output logic             cnt_clr,
  output logic             cnt_inc,
  output ifs_phase_e       phase,
  output logic             sof_permit,
  output logic             overload
);
  localparam logic [CNT_W-1:0] INTER_LAST = CNT_W'(INTER_BITS - 1);
  localparam logic [CNT_W-1:0] SUSP_LAST  = CNT_W'(SUSP_BITS - 1);

  ifs_phase_e nxt_phase;
  logic       ovl_set;
  logic       ovl_clr;
  logic       dominant;

  assign dominant = ~bus_bit;

  always_comb begin
    nxt_phase = phase;
    cnt_clr   = 1'b0;
    cnt_inc   = 1'b0;
    ovl_set   = 1'b0;
    ovl_clr   = 1'b0;
    if (bit_tick) begin
      if (errovl_start) begin
        nxt_phase = PH_FRAME;
        cnt_clr   = 1'b1;
      end else if (eof_done) begin
        nxt_phase = PH_INTERMISSION;
        cnt_clr   = 1'b1;
        ovl_clr   = 1'b1;
      end else begin
        unique case (phase)
          PH_INTERMISSION: begin
            if (dominant) begin
              nxt_phase = PH_FRAME;
              cnt_clr   = 1'b1;
              ovl_set   = 1'b1;
            end else if (count == INTER_LAST) begin
              nxt_phase = need_suspend ? PH_SUSPEND : PH_IDLE;
              cnt_clr   = 1'b1;
            end else begin
              cnt_inc = 1'b1;
            end
          end
          PH_SUSPEND: begin
            if (dominant) begin
              nxt_phase = PH_FRAME;
              cnt_clr   = 1'b1;
            end else if (count == SUSP_LAST) begin
              nxt_phase = PH_IDLE;
              cnt_clr   = 1'b1;
            end else begin
              cnt_inc = 1'b1;
            end
          end
          PH_IDLE: begin
            if (dominant) nxt_phase = PH_FRAME;
          end
          default: nxt_phase = PH_FRAME;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      sof_permit <= 1'b0;
      overload   <= 1'b0;
    end else if (bit_tick) begin
      phase      <= nxt_phase;
      sof_permit <= (nxt_phase == PH_IDLE) && tx_pending;
      if (ovl_set)      overload <= 1'b1;
      else if (ovl_clr) overload <= 1'b0;
    end
  end
endmodule

// File: rtl/ifs_sequencer.sv
module ifs_sequencer
  import ifs_pkg::*;
#(
  parameter int INTER_BITS = 3,
  parameter int SUSP_BITS  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_tick,
  input  logic       bus_bit,
  input  logic       eof_done,
  input  logic       tx_was_mine,
  input  logic       err_passive,
  input  logic       tx_pending,
  input  logic       errovl_start,
  output logic [1:0] phase,
  output logic       sof_permit,
  output logic       overload
);
  localparam int LONGEST = (INTER_BITS > SUSP_BITS) ? INTER_BITS : SUSP_BITS;
  localparam int CNT_W   = $clog2(LONGEST + 1);

  logic             cnt_clr;
  logic             cnt_inc;
  logic [CNT_W-1:0] count;
  logic             need_suspend;
  ifs_phase_e       phase_q;

  ifs_field_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .count (count)
  );

  ifs_suspend_flag u_susp (
    .clk          (clk),
    .rst          (rst),
    .capture      (bit_tick & eof_done & ~errovl_start),
    .err_passive  (err_passive),
    .tx_was_mine  (tx_was_mine),
    .need_suspend (need_suspend)
  );

  ifs_phase_ctrl #(
    .INTER_BITS (INTER_BITS),
    .SUSP_BITS  (SUSP_BITS),
    .CNT_W      (CNT_W)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .bit_tick     (bit_tick),
    .bus_bit      (bus_bit),
    .eof_done     (eof_done),
    .errovl_start (errovl_start),
    .tx_pending   (tx_pending),
    .need_suspend (need_suspend),
    .count        (count),
    .cnt_clr      (cnt_clr),
    .cnt_inc      (cnt_inc),
    .phase        (phase_q),
    .sof_permit   (sof_permit),
    .overload     (overload)
  );

  assign phase = phase_q;
endmodule

// File: rtl/ifs_sequencer_chk.sv
module ifs_sequencer_chk (
  input logic       clk,
  input logic       rst,
  input logic       bit_tick,
  input logic       bus_bit,
  input logic       eof_done,
  input logic       errovl_start,
  input logic [1:0] phase,
  input logic       sof_permit,
  input logic       overload
);
  // R10: nothing moves between strobes
  a_r10_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    !bit_tick |=> ($stable(phase) && $stable(sof_permit) && $stable(overload)));

  // R6: permit only while idle
  a_r6_permit_only_idle: assert property (@(posedge clk) disable iff (rst)
    sof_permit |-> (phase == 2'd0));

  // R9: error/overload frame starts without a gap
  a_r9_errovl_to_frame: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && errovl_start) |=> (phase == 2'd3));

  // R2: frame end opens intermission
  a_r2_eof_to_intermission: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && eof_done && !errovl_start) |=> (phase == 2'd1 && !overload));

  // R7: dominant in intermission flags overload
  a_r7_overload_set: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && phase == 2'd1 && !bus_bit && !eof_done && !errovl_start)
      |=> (overload && phase == 2'd3));

  // R5: dominant in idle is a foreign start-of-frame
  a_r5_idle_dominant: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && phase == 2'd0 && !bus_bit && !eof_done && !errovl_start)
      |=> (phase == 2'd3 && !sof_permit));

  // R8: dominant in suspend is a foreign start-of-frame
  a_r8_suspend_dominant: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && phase == 2'd2 && !bus_bit && !eof_done && !errovl_start)
      |=> (phase == 2'd3 && !sof_permit));
endmodule

bind ifs_sequencer ifs_sequencer_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .bit_tick     (bit_tick),
  .bus_bit      (bus_bit),
  .eof_done     (eof_done),
  .errovl_start (errovl_start),
  .phase        (phase),
  .sof_permit   (sof_permit),
  .overload     (overload)
);

// File: tb/ifs_sequencer_tb.sv
`timescale 1ns/1ps
module ifs_sequencer_tb;
  localparam int INTER = 3;
  localparam int SUSP  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_tick = 1'b0, bus_bit = 1'b1, eof_done = 1'b0;
  logic tx_was_mine = 1'b0, err_passive = 1'b0, tx_pending = 1'b0, errovl_start = 1'b0;
  logic [1:0] phase;
  logic sof_permit, overload;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;

  // reference model state
  int m_phase = 0, m_left = 0;
  bit m_susp = 0, m_permit = 0, m_ovl = 0;

  always #10 clk = ~clk;

  ifs_sequencer #(.INTER_BITS(INTER), .SUSP_BITS(SUSP)) u_dut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .bus_bit(bus_bit),
    .eof_done(eof_done), .tx_was_mine(tx_was_mine), .err_passive(err_passive),
    .tx_pending(tx_pending), .errovl_start(errovl_start),
    .phase(phase), .sof_permit(sof_permit), .overload(overload)
  );

  task automatic expect_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // behavioural model, advanced on the same edge as the design
  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_left = 0; m_susp = 0; m_permit = 0; m_ovl = 0;
    end else if (bit_tick) begin
      if (errovl_start) m_phase = 3;
      else if (eof_done) begin
        m_phase = 1; m_left = INTER; m_susp = err_passive && tx_was_mine; m_ovl = 0;
      end else if (m_phase == 1) begin
        if (!bus_bit) begin m_ovl = 1; m_phase = 3; end
        else begin
          m_left--;
          if (m_left == 0) begin
            if (m_susp) begin m_phase = 2; m_left = SUSP; end
            else m_phase = 0;
          end
        end
      end else if (m_phase == 2) begin
        if (!bus_bit) m_phase = 3;
        else begin
          m_left--;
          if (m_left == 0) m_phase = 0;
        end
      end else if (m_phase == 0) begin
        if (!bus_bit) m_phase = 3;
      end
      m_permit = (m_phase == 0) && tx_pending;
    end
  end

  // every-clock comparison
  always @(negedge clk) begin
    if (!rst) begin
      case (m_phase)
        1: expect_eq("R2 phase", int'(phase), m_phase);
        2: expect_eq("R3 phase", int'(phase), m_phase);
        0: expect_eq("R5 phase", int'(phase), m_phase);
        default: expect_eq("R9 phase", int'(phase), m_phase);
      endcase
      expect_eq("R6 permit", int'(sof_permit), int'(m_permit));
      expect_eq("R7 overload", int'(overload), int'(m_ovl));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cycles);
      finish_run();
    end
  end

  // one bit: strobe cycle, then three cycles of noise that must be ignored (R10)
  task automatic send_bit(input logic b, input logic eof, input logic eo);
    @(negedge clk);
    bus_bit = b; eof_done = eof; errovl_start = eo; bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0; bus_bit = ~b; eof_done = 1'b1; errovl_start = 1'b1;
    @(negedge clk);
    @(negedge clk);
    eof_done = 1'b0; errovl_start = 1'b0;
  endtask

  task automatic rec(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_eq("R1 phase in reset", int'(phase), 0);
    expect_eq("R1 permit in reset", int'(sof_permit), 0);
    expect_eq("R1 overload in reset", int'(overload), 0);
    rst = 1'b0;
    @(negedge clk);
    expect_eq("R1 phase after reset", int'(phase), 0);

    // R10: dominant and eof with no strobe leave idle untouched
    bus_bit = 1'b0; eof_done = 1'b1; errovl_start = 1'b1;
    repeat (4) @(negedge clk);
    expect_eq("R10 no strobe no change", int'(phase), 0);
    bus_bit = 1'b1; eof_done = 1'b0; errovl_start = 1'b0;

    // R2 / R4: error-active transmitter, plain gap
    tx_was_mine = 1'b1; err_passive = 1'b0;
    send_bit(1'b1, 1'b1, 1'b0);
    expect_eq("R2 intermission after eof", int'(phase), 1);
    rec(INTER - 1);
    expect_eq("R2 still intermission", int'(phase), 1);
    rec(1);
    expect_eq("R4 active skips suspend", int'(phase), 0);
    rec(20);
    expect_eq("R5 idle persists", int'(phase), 0);

    // R6: pending frame permitted on first bit after intermission
    tx_pending = 1'b1;
    send_bit(1'b1, 1'b1, 1'b0);
    rec(INTER - 1);
    expect_eq("R6 no permit during intermission", int'(sof_permit), 0);
    rec(1);
    expect_eq("R6 permit after intermission", int'(sof_permit), 1);
    send_bit(1'b0, 1'b0, 1'b0);
    expect_eq("R5 sof dominant enters frame", int'(phase), 3);
    expect_eq("R5 permit dropped in frame", int'(sof_permit), 0);

    // R3: error-passive transmitter inserts suspend
    err_passive = 1'b1; tx_was_mine = 1'b1;
    send_bit(1'b1, 1'b1, 1'b0);
    rec(INTER);
    expect_eq("R3 suspend entered", int'(phase), 2);
    expect_eq("R6 no permit in suspend", int'(sof_permit), 0);
    rec(SUSP - 1);
    expect_eq("R3 still suspend", int'(phase), 2);
    rec(1);
    expect_eq("R3 idle after suspend", int'(phase), 0);
    expect_eq("R6 permit after suspend", int'(sof_permit), 1);
    send_bit(1'b0, 1'b0, 1'b0);

    // R4: passive receiver skips suspend
    tx_was_mine = 1'b0;
    send_bit(1'b1, 1'b1, 1'b0);
    rec(INTER);
    expect_eq("R4 passive receiver skips suspend", int'(phase), 0);
    send_bit(1'b0, 1'b0, 1'b0);

    // R8: dominant during suspend
    tx_was_mine = 1'b1;
    send_bit(1'b1, 1'b1, 1'b0);
    rec(INTER + 2);
    send_bit(1'b0, 1'b0, 1'b0);
    expect_eq("R8 suspend dominant to frame", int'(phase), 3);
    expect_eq("R8 no permit after foreign sof", int'(sof_permit), 0);
    expect_eq("R8 no overload from suspend", int'(overload), 0);
    rec(SUSP + 2);
    expect_eq("R8 stays in frame", int'(phase), 3);

    // R7: dominant during intermission
    err_passive = 1'b0;
    send_bit(1'b1, 1'b1, 1'b0);
    rec(1);
    send_bit(1'b0, 1'b0, 1'b0);
    expect_eq("R7 overload set", int'(overload), 1);
    expect_eq("R7 phase frame", int'(phase), 3);
    rec(6);
    expect_eq("R7 overload held", int'(overload), 1);
    send_bit(1'b1, 1'b1, 1'b0);
    expect_eq("R7 overload cleared by eof", int'(overload), 0);
    expect_eq("R7 intermission restarted", int'(phase), 1);

    // R9: error frame starts mid-intermission and from idle; wins over eof
    send_bit(1'b0, 1'b0, 1'b1);
    expect_eq("R9 errovl in intermission", int'(phase), 3);
    send_bit(1'b1, 1'b1, 1'b0);
    rec(INTER);
    expect_eq("R9 back to idle", int'(phase), 0);
    send_bit(1'b1, 1'b1, 1'b1);
    expect_eq("R9 errovl beats eof", int'(phase), 3);
    send_bit(1'b1, 1'b1, 1'b0);
    rec(INTER);
    tx_pending = 1'b0;
    rec(1);
    expect_eq("R6 permit follows pending", int'(sof_permit), 0);

    // R1: reset from mid-gap
    send_bit(1'b1, 1'b1, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    expect_eq("R1 reset returns idle", int'(phase), 0);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule